// File: doc/BRIEF.md
# Endpoint Code Download Address Generator

This block turns a stream of incoming code words on three USB endpoints into write cycles for a processor program memory. Each channel keeps an 18-bit base address and an 18-bit running offset. A control processor writes the base through a small register port, and both values can be read back through that port. Each data word accepted on a channel first advances that channel's offset by one. The word is then written to memory at base plus the new offset.

Writing a base register reloads the channel's offset to all ones, which is minus one. As a result, base plus offset always names the most recent location written on that channel, and the first word after a base write lands exactly on the base. The three channels share a single memory write port. When more than one channel has a word ready in the same cycle, the lowest-numbered channel is served first. The other channels keep their words presented until they are acknowledged.

Top module: `cdl_addr_gen`

## Requirements
- R1: After reset every base reads 0, every offset reads 0x3FFFF, `mem_we` is low and `reg_rdata` is 0.
- R2: A register write to a channel's base stores the value, and in the next cycle that channel's offset reads 0x3FFFF.
- R3: For each accepted word, the channel's offset increases by one. In the cycle after acceptance, `mem_we` is high, `mem_addr` equals base plus the new offset and `mem_wdata` carries the word. With no accepted word, `mem_we` is low.
- R4: The first word accepted after a base write is written at exactly the base address.
- R5: The offset register is read-only. A register write to an offset address leaves the offset value unchanged.
- R6: If a base write and a valid word hit the same channel in the same cycle, the base write takes effect. The word is acknowledged but dropped: no memory write occurs and the offset stays at 0x3FFFF.
- R7: When several channels present words in one cycle, only the lowest channel index among them (channel 0 is endpoint 1) is acknowledged. The others see `word_ack` low and keep their word.
- R8: Address arithmetic wraps modulo 2^18. With base 0x3FFFF, two words go to 0x3FFFF and then 0x00000, and no error is raised.
- R9: Register map: `reg_addr[2:1]` selects the channel (0, 1, 2). `reg_addr[0]`=0 selects the base and `reg_addr[0]`=1 selects the offset. A read returns its data on `reg_rdata` one cycle after `reg_rd`, and channel index 3 reads as 0.
- R10: Channels are independent. A base write or word on one channel leaves the base and offset of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select: channel index and base/offset bit |
| reg_wdata | input | 18 | Register write data |
| reg_rdata | output | 18 | Registered read data |
| word_valid | input | 3 | Per-channel word present |
| word_data | input | 72 | Per-channel word, channel i in bits [24*i+23:24*i] |
| word_ack | output | 3 | Word taken this cycle (written or dropped) |
| mem_we | output | 1 | Program memory write enable |
| mem_addr | output | 18 | Program memory write address |
| mem_wdata | output | 24 | Program memory write data |

## Verification
The bench builds the block with its default parameters: three channels, 18-bit addresses and 24-bit words. The 18-bit address width matters because a base of 0x3FFFF then carries the second word across the top of the address space within two cycles. Three channels are the smallest count in which a middle channel can both lose arbitration to a lower channel and win against a higher one, so one run covers the full priority order. The run also covers the same-channel collision between a base write and a word.

// File: rtl/cdl_pkg.sv
package cdl_pkg;
  typedef enum logic {
    SEL_BASE   = 1'b0,
    SEL_OFFSET = 1'b1
  } reg_sel_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cdl_channel.sv
module cdl_channel #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              advance,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] off_q,
  output logic [ADDR_W-1:0] next_addr
);
  localparam logic [ADDR_W-1:0] OFF_RELOAD = '1;
  localparam logic [ADDR_W-1:0] ONE        = ADDR_W'(1);

  logic [ADDR_W-1:0] off_inc;

  assign off_inc   = off_q + ONE;
  assign next_addr = base_q + off_inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      off_q  <= OFF_RELOAD;
    end else if (base_wr) begin
      base_q <= base_wdata;
      off_q  <= OFF_RELOAD;
    end else if (advance) begin
      off_q  <= off_inc;
    end
  end

  // R2
  off_reload_chk: assert property (@(posedge clk) disable iff (rst)
    base_wr |=> (off_q == OFF_RELOAD) && (base_q == $past(base_wdata)));

  // R3
  off_step_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && !base_wr) |=> (off_q == ADDR_W'($past(off_q) + ONE)));

  // R10
  chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!advance && !base_wr) |=> ($stable(off_q) && $stable(base_q)));
endmodule

// File: rtl/cdl_prio_arb.sv
module cdl_prio_arb #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [N:0] taken;

  assign taken[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_lane
    assign taken[i+1] = taken[i] | req[i];
    assign gnt[i]     = req[i] & ~taken[i];
  end

  always_comb begin
    // R7
    gnt_onehot_chk: assert ($onehot0(gnt));
    // R7
    gnt_subset_chk: assert ((gnt & ~req) == '0);
  end
endmodule

// File: rtl/cdl_regif.sv
module cdl_regif
  import cdl_pkg::*;
#(
  parameter int NUM_EP = 3,
  parameter int ADDR_W = 18,
  parameter int IDX_W  = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         reg_wr,
  input  logic                         reg_rd,
  input  logic [IDX_W:0]               reg_addr,
  input  logic [NUM_EP-1:0][ADDR_W-1:0] base_v,
  input  logic [NUM_EP-1:0][ADDR_W-1:0] off_v,
  output logic [NUM_EP-1:0]            base_wr,
  output logic [ADDR_W-1:0]            reg_rdata
);
  logic [IDX_W-1:0]  idx;
  reg_sel_e          sel;
  logic [ADDR_W-1:0] rd_mux;

  assign idx = reg_addr[IDX_W:1];
  assign sel = reg_sel_e'(reg_addr[0]);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_dec
    assign base_wr[i] = reg_wr && (sel == SEL_BASE) && (idx == IDX_W'(i));
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (idx == IDX_W'(i)) begin
        rd_mux = (sel == SEL_BASE) ? base_v[i] : off_v[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= rd_mux;
    end
  end

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));

  // R5
  wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(base_wr));
endmodule

// File: rtl/cdl_addr_gen.sv
module cdl_addr_gen
  import cdl_pkg::*;
#(
  parameter int NUM_EP = 3,
  parameter int ADDR_W = 18,
  parameter int DATA_W = 24,
  localparam int IDX_W = idx_width(NUM_EP)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [IDX_W:0]           reg_addr,
  input  logic [ADDR_W-1:0]        reg_wdata,
  output logic [ADDR_W-1:0]        reg_rdata,
  input  logic [NUM_EP-1:0]        word_valid,
  input  logic [NUM_EP*DATA_W-1:0] word_data,
  output logic [NUM_EP-1:0]        word_ack,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [DATA_W-1:0]        mem_wdata
);
  logic [NUM_EP-1:0][ADDR_W-1:0] base_v;
  logic [NUM_EP-1:0][ADDR_W-1:0] off_v;
  logic [NUM_EP-1:0][ADDR_W-1:0] next_v;
  logic [NUM_EP-1:0]             base_wr;
  logic [NUM_EP-1:0]             req;
  logic [NUM_EP-1:0]             gnt;
  logic [NUM_EP-1:0]             drop;
  logic [ADDR_W-1:0]             addr_d;
  logic [DATA_W-1:0]             data_d;

  cdl_regif #(
    .NUM_EP(NUM_EP),
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W)
  ) u_regif (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .base_v   (base_v),
    .off_v    (off_v),
    .base_wr  (base_wr),
    .reg_rdata(reg_rdata)
  );

  assign drop     = word_valid & base_wr;
  assign req      = word_valid & ~base_wr;
  assign word_ack = gnt | drop;

  cdl_prio_arb #(.N(NUM_EP)) u_arb (
    .req(req),
    .gnt(gnt)
  );

  for (genvar i = 0; i < NUM_EP; i++) begin : g_chan
    cdl_channel #(.ADDR_W(ADDR_W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .base_wr   (base_wr[i]),
      .base_wdata(reg_wdata),
      .advance   (gnt[i]),
      .base_q    (base_v[i]),
      .off_q     (off_v[i]),
      .next_addr (next_v[i])
    );
  end

  always_comb begin
    addr_d = '0;
    data_d = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (gnt[i]) begin
        addr_d = addr_d | next_v[i];
        data_d = data_d | word_data[i*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we    <= |gnt;
      mem_addr  <= addr_d;
      mem_wdata <= data_d;
    end
  end

  // R3
  we_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (|gnt) |=> mem_we);

  // R3
  we_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(|gnt) |=> !mem_we);

  // R6
  drop_nowr_chk: assert property (@(posedge clk) disable iff (rst)
    ((drop != '0) && (req == '0)) |=> !mem_we);
endmodule

// File: tb/cdl_addr_gen_tb.sv
`timescale 1ns/1ps
module cdl_addr_gen_tb;
  localparam int NE = 3;
  localparam int AW = 18;
  localparam int DW = 24;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            reg_wr = 1'b0;
  logic            reg_rd = 1'b0;
  logic [2:0]      reg_addr = '0;
  logic [AW-1:0]   reg_wdata = '0;
  logic [AW-1:0]   reg_rdata;
  logic [NE-1:0]   word_valid = '0;
  logic [NE*DW-1:0] word_data = '0;
  logic [NE-1:0]   word_ack;
  logic            mem_we;
  logic [AW-1:0]   mem_addr;
  logic [DW-1:0]   mem_wdata;

  cdl_addr_gen u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .word_valid(word_valid), .word_data(word_data), .word_ack(word_ack),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [AW+DW-1:0] expq[$];
  logic [AW-1:0] m_base [NE];
  logic [AW-1:0] m_off  [NE];
  logic          pend_v [NE];
  logic [DW-1:0] pend_d [NE];

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic give(input int ep, input logic [DW-1:0] d);
    pend_v[ep] = 1'b1;
    pend_d[ep] = d;
  endtask

  // One cycle: present pending words, optional base write on bw_ep
  task automatic step(input string tag, input int bw_ep, input logic [AW-1:0] bw_val);
    logic [NE-1:0] exp_ack;
    logic [NE-1:0] dropm;
    bit won;
    exp_ack = '0;
    dropm = '0;
    won = 0;
    for (int i = 0; i < NE; i++) begin
      word_valid[i] = pend_v[i];
      word_data[i*DW +: DW] = pend_d[i];
    end
    if (bw_ep >= 0) begin
      reg_wr = 1'b1;
      reg_addr = {2'(bw_ep), 1'b0};
      reg_wdata = bw_val;
      if (pend_v[bw_ep]) dropm[bw_ep] = 1'b1;
      m_base[bw_ep] = bw_val;
      m_off[bw_ep] = '1;
    end
    for (int i = 0; i < NE; i++) begin
      if (!won && pend_v[i] && !dropm[i]) begin
        won = 1;
        exp_ack[i] = 1'b1;
        m_off[i] = m_off[i] + 1'b1;
        expq.push_back({m_base[i] + m_off[i], pend_d[i]});
      end
    end
    exp_ack = exp_ack | dropm;
    #1;
    chk({tag, " ack"}, 64'(word_ack), 64'(exp_ack));
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
    for (int i = 0; i < NE; i++) if (exp_ack[i]) pend_v[i] = 1'b0;
    for (int i = 0; i < NE; i++) word_valid[i] = 1'b0;
  endtask

  task automatic rd(input string tag, input int ep, input bit off, input logic [AW-1:0] exp);
    reg_rd = 1'b1;
    reg_addr = {2'(ep), off};
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0;
    chk(tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic wr_off(input int ep, input logic [AW-1:0] v);
    reg_wr = 1'b1;
    reg_addr = {2'(ep), 1'b1};
    reg_wdata = v;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // Scoreboard monitor (R3)
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (expq.size() == 0) begin
        chk("R3 unexpected write", 64'(mem_addr), 64'hFFFF_FFFF);
      end else begin
        logic [AW+DW-1:0] e;
        e = expq.pop_front();
        chk("R3 mem write", 64'({mem_addr, mem_wdata}), 64'(e));
      end
    end
  end

  bit done = 0;

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NE; i++) begin
      m_base[i] = '0;
      m_off[i] = '1;
      pend_v[i] = 1'b0;
      pend_d[i] = '0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 mem_we", 64'(mem_we), 64'd0);
    chk("R1 rdata", 64'(reg_rdata), 64'd0);
    rd("R1 base0", 0, 0, 18'h0);
    rd("R1 off2", 2, 1, 18'h3FFFF);

    // R2 base write reloads offset; R4 first word lands on base
    step("R2 base0", 0, 18'h01000);
    rd("R2 off0", 0, 1, 18'h3FFFF);
    rd("R2 base0", 0, 0, 18'h01000);
    give(0, 24'hA00001); step("R4 w0", -1, '0);
    give(0, 24'hA00002); step("R3 w1", -1, '0);
    give(0, 24'hA00003); step("R3 w2", -1, '0);
    rd("R3 off0 after 3", 0, 1, 18'h00002);

    // R7 priority with all three channels
    step("R10 base1", 1, 18'h02000);
    step("R10 base2", 2, 18'h03000);
    rd("R10 base0 kept", 0, 0, 18'h01000);
    rd("R10 off0 kept", 0, 1, 18'h00002);
    give(0, 24'hB00000); give(1, 24'hB11111); give(2, 24'hB22222);
    step("R7 round a", -1, '0);
    step("R7 round b", -1, '0);
    step("R7 round c", -1, '0);
    give(1, 24'hC11111); give(2, 24'hC22222);
    step("R7 mid wins", -1, '0);
    step("R7 high last", -1, '0);

    // R6 collision: base write beats word on same channel
    give(1, 24'hD11111);
    step("R6 collide", 1, 18'h02500);
    rd("R6 off1", 1, 1, 18'h3FFFF);
    give(1, 24'hD22222); step("R4 after collide", -1, '0);

    // R6 with another channel winning in the same cycle
    give(0, 24'hE00000); give(2, 24'hE22222);
    step("R6 drop plus grant", 2, 18'h03100);
    rd("R6 off2", 2, 1, 18'h3FFFF);

    // R5 offset is read-only
    give(2, 24'hF22222); step("R5 prep", -1, '0);
    wr_off(2, 18'h00055);
    rd("R5 off2 unchanged", 2, 1, 18'h00000);
    rd("R5 base2 unchanged", 2, 0, 18'h03100);

    // R8 wrap at top of address space
    step("R8 base2 top", 2, 18'h3FFFF);
    give(2, 24'h123456); step("R8 w top", -1, '0);
    give(2, 24'h654321); step("R8 w wrap", -1, '0);
    rd("R8 off2", 2, 1, 18'h00001);

    // R9 unmapped channel index reads zero
    rd("R9 idx3 base", 3, 0, 18'h0);
    rd("R9 idx3 off", 3, 1, 18'h0);

    repeat (4) @(negedge clk);
    chk("R3 queue drained", 64'(expq.size()), 64'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule